// File: doc/BRIEF.md
# Ping-Pong Receive Bank Controller

This block takes a stream of fixed-length messages from up to eight receive channels and writes them into one of two storage banks of equal size. When a bank holds at least one complete message and the host holds no bank, the block gives that bank to the host, raises a one-cycle interrupt pulse and moves its writes to the other bank. The host reads the bank through a memory window, then gives it back by setting a release bit in the command register. Giving it back swaps the roles of the banks again.

After a release the interrupt comes at once if the waiting bank already holds a complete message. If the waiting bank is empty, the interrupt comes when the first message in it completes. A release that arrives while a message is only partly written is held back: the handover and its pulse wait for the end of that message, so a handed-over bank never contains a partial message. Each pulse stands for exactly one handover, and no handover goes without a pulse. The host can therefore depend on edges alone.

The host sees 32-bit words through a small register map at word addresses: a status register at 0, a command register at 1, and the bank window from address BANK_WORDS upward. A read returns its data on the cycle after the request.

Top module: `rxpp_pingpong`

## Requirements
- R1: After reset the status register reads 0, no bank is handed over and `irq` stays low.
- R2: A message that completes while the host holds no bank hands the filling bank over. The same clock edge sets that bank's ready bit and produces one `irq` pulse.
- R3: Message words are stored in arrival order and read at window address BANK_WORDS + message_index*MSG_WORDS + word_index, with the data on the cycle after the request. The first word of each message is stored with bits 31:29 replaced by the 3-bit channel tag and bits 28:0 kept. Every other word is stored unchanged. `in_last` comes with the final word of each message.
- R4: While the host holds a bank, completed messages go to the other bank and raise no interrupt. The status register reports: bit 0 = bank 0 ready, bit 1 = bank 1 ready, bit 2 = overflow, bit 3 = index of the bank last handed over, bits 17:8 = message count of bank 0, bits 27:18 = message count of bank 1. All other bits read 0.
- R5: Writing the command register (address 1) with bit 0 releases bank 0, and with bit 1 releases bank 1. If the other bank holds at least one complete message, it is handed over on the same edge with one `irq` pulse. At most one ready bit is ever set.
- R6: If the other bank is empty at release time, both ready bits read 0 and no pulse occurs until the next message completes. That message then hands the bank over with one pulse.
- R7: A release bit for a bank that is not handed over has no effect, also when it is combined with a valid release in the same write. The command register reads back 0.
- R8: A released bank's message count returns to 0, and the bank becomes the next filling bank.
- R9: A message that starts while the filling bank holds BANK_WORDS/MSG_WORDS messages is dropped whole, and status bit 2 is set and stays set. Writing 1 to bit 2 of the status register clears it.
- R10: A release that arrives while a message is partly written into the filling bank moves the handover and its pulse to the cycle that completes that message.
- R11: Every new ready bit comes with an `irq` pulse on the same edge. Two handovers on consecutive cycles give two separate pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message word present |
| in_data | input | 32 | Message word |
| in_chan | input | 3 | Channel tag of the message |
| in_last | input | 1 | Final word of the message |
| hb_en | input | 1 | Host access strobe |
| hb_we | input | 1 | Host access is a write |
| hb_addr | input | $clog2(BANK_WORDS)+1 | Host word address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid the cycle after a read |
| irq | output | 1 | One-cycle handover pulse |

## Verification
The assertions assume that the message source sends exactly MSG_WORDS words per message and raises `in_last` only on the last of them. One property checks this assumption against the internal word counter. The bench's message task always produces words in whole messages, with idle cycles only between words. The assertions also assume that host accesses are single-cycle strobes. The bench issues each register write or read as a strobe of exactly one cycle. It brings in a release in the middle of a message only in one directed case.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TAG_W     = 3;
  localparam int unsigned CNT_FLD_W = 10;

  typedef enum logic [1:0] {
    HB_STATUS,
    HB_CMD,
    HB_WINDOW,
    HB_UNMAPPED
  } hb_sel_e;

  // First word of a message carries the channel tag in its top bits.
  function automatic logic [WORD_W-1:0] tag_first(input logic [WORD_W-1:0] d,
                                                   input logic [TAG_W-1:0] ch);
    return {ch, d[WORD_W-TAG_W-1:0]};
  endfunction

  // Word offset inside a bank for a given message slot and word.
  function automatic int unsigned slot_addr(input int unsigned msg_idx,
                                            input int unsigned word_idx,
                                            input int unsigned msg_words);
    return msg_idx * msg_words + word_idx;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [1:0] rdy,
                                                    input logic ovf,
                                                    input logic hsel,
                                                    input logic [CNT_FLD_W-1:0] c0,
                                                    input logic [CNT_FLD_W-1:0] c1);
    return {4'b0, c1, c0, 4'b0, hsel, ovf, rdy};
  endfunction

endpackage

// File: rtl/rxpp_bank_mem.sv
module rxpp_bank_mem #(
  parameter int BANK_WORDS = 1024,
  localparam int BA_W = $clog2(BANK_WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [BA_W-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [BA_W-1:0] rd_addr,
  output logic [63:0]   rd_flat
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [31:0] mem [BANK_WORDS];
    logic [31:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      if (rd_en) q <= mem[rd_addr];
    end

    assign rd_flat[b*32 +: 32] = q;
  end

endmodule

// File: rtl/rxpp_ingress.sv
module rxpp_ingress #(
  parameter int MSG_WORDS  = 4,
  parameter int BANK_WORDS = 1024,
  parameter int CNT_W      = 9,
  localparam int BA_W = $clog2(BANK_WORDS),
  localparam int WP_W = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_data,
  input  logic [2:0]      in_chan,
  input  logic            in_last,
  input  logic            fill_sel,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic            fill_full,
  output logic            wr_en,
  output logic            wr_bank,
  output logic [BA_W-1:0] wr_addr,
  output logic [31:0]     wr_data,
  output logic            msg_done,
  output logic            msg_drop,
  output logic            busy_next,
  output logic            writing,
  output logic [WP_W-1:0] wptr
);

  logic drop_q;
  logic first;
  logic drop_now;

  assign first    = (wptr == '0);
  assign drop_now = first ? fill_full : drop_q;
  assign wr_en    = in_valid && !drop_now;
  assign msg_done = wr_en && in_last;
  assign msg_drop = in_valid && first && fill_full;
  assign busy_next = wr_en ? !in_last : writing;
  assign wr_bank  = fill_sel;
  assign wr_data  = first ? rxpp_pkg::tag_first(in_data, in_chan) : in_data;
  assign wr_addr  = BA_W'(rxpp_pkg::slot_addr(32'(fill_cnt), 32'(wptr), MSG_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      drop_q  <= 1'b0;
      writing <= 1'b0;
    end else begin
      writing <= busy_next;
      if (in_valid) begin
        wptr   <= in_last ? '0 : wptr + 1'b1;
        drop_q <= in_last ? 1'b0 : drop_now;
      end
    end
  end

endmodule

// File: rtl/rxpp_bank_ctrl.sv
module rxpp_bank_ctrl #(
  parameter int MAX_MSGS = 256,
  parameter int CNT_W    = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_done,
  input  logic            msg_drop,
  input  logic            busy_next,
  input  logic [1:0]      rel_req,
  input  logic            ovf_clr,
  output logic [1:0]      rdy,
  output logic            hsel,
  output logic            fill_sel,
  output logic [CNT_W-1:0] fill_cnt,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1,
  output logic            fill_full,
  output logic            ovf,
  output logic [1:0]      rel_hit,
  output logic            irq
);

  logic [CNT_W-1:0] cnt_q [2];
  logic held_after;
  logic handover;

  assign rel_hit    = rel_req & rdy;
  assign held_after = |(rdy & ~rel_hit);
  assign fill_cnt   = cnt_q[fill_sel];
  assign fill_full  = (fill_cnt == CNT_W'(MAX_MSGS));
  assign handover   = !held_after && ((fill_cnt != '0) || msg_done) && !busy_next;
  assign cnt0       = cnt_q[0];
  assign cnt1       = cnt_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) cnt_q[b] <= '0;
      rdy      <= '0;
      hsel     <= 1'b0;
      fill_sel <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (rel_hit[b]) begin
          cnt_q[b] <= '0;
          rdy[b]   <= 1'b0;
        end else begin
          if (msg_done && (fill_sel == 1'(b))) cnt_q[b] <= cnt_q[b] + 1'b1;
          if (handover && (fill_sel == 1'(b))) rdy[b] <= 1'b1;
        end
      end
      if (handover) begin
        hsel     <= fill_sel;
        fill_sel <= ~fill_sel;
      end
      if (msg_drop)     ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      irq <= handover;
    end
  end

endmodule

// File: rtl/rxpp_host_regs.sv
module rxpp_host_regs #(
  parameter int BANK_WORDS = 1024,
  parameter int CNT_W      = 9,
  localparam int BA_W = $clog2(BANK_WORDS),
  localparam int HA_W = BA_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_en,
  input  logic            hb_we,
  input  logic [HA_W-1:0] hb_addr,
  input  logic [31:0]     hb_wdata,
  input  logic [1:0]      rdy,
  input  logic            ovf,
  input  logic            hsel,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic [63:0]     rd_flat,
  output logic [1:0]      rel_req,
  output logic            ovf_clr,
  output logic            rd_en,
  output logic [BA_W-1:0] rd_addr,
  output logic [31:0]     hb_rdata
);
  import rxpp_pkg::*;

  hb_sel_e     sel;
  logic        win_q;
  logic        bank_q;
  logic [31:0] reg_q;
  logic        unused_wdata;

  assign unused_wdata = ^hb_wdata[31:3];

  always_comb begin
    if (hb_addr[HA_W-1])                   sel = HB_WINDOW;
    else if (hb_addr == HA_W'(0))          sel = HB_STATUS;
    else if (hb_addr == HA_W'(1))          sel = HB_CMD;
    else                                   sel = HB_UNMAPPED;
  end

  assign rel_req = (hb_en && hb_we && (sel == HB_CMD)) ? hb_wdata[1:0] : 2'b00;
  assign ovf_clr = hb_en && hb_we && (sel == HB_STATUS) && hb_wdata[2];
  assign rd_en   = hb_en && !hb_we && (sel == HB_WINDOW);
  assign rd_addr = hb_addr[BA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      bank_q <= 1'b0;
      reg_q  <= '0;
    end else if (hb_en && !hb_we) begin
      win_q  <= (sel == HB_WINDOW);
      bank_q <= hsel;
      reg_q  <= (sel == HB_STATUS)
                ? pack_status(rdy, ovf, hsel, CNT_FLD_W'(cnt0), CNT_FLD_W'(cnt1))
                : '0;
    end
  end

  assign hb_rdata = win_q ? (bank_q ? rd_flat[63:32] : rd_flat[31:0]) : reg_q;

endmodule

// File: rtl/rxpp_pingpong.sv
module rxpp_pingpong #(
  parameter int MSG_WORDS  = 4,
  parameter int BANK_WORDS = 1024,
  localparam int MAX_MSGS = BANK_WORDS / MSG_WORDS,
  localparam int CNT_W    = $clog2(MAX_MSGS + 1),
  localparam int BA_W     = $clog2(BANK_WORDS),
  localparam int HA_W     = BA_W + 1,
  localparam int WP_W     = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_data,
  input  logic [2:0]      in_chan,
  input  logic            in_last,
  input  logic            hb_en,
  input  logic            hb_we,
  input  logic [HA_W-1:0] hb_addr,
  input  logic [31:0]     hb_wdata,
  output logic [31:0]     hb_rdata,
  output logic            irq
);

  logic            wr_en, wr_bank;
  logic [BA_W-1:0] wr_addr, rd_addr;
  logic [31:0]     wr_data;
  logic            msg_done, msg_drop, busy_next, writing;
  logic [WP_W-1:0] wptr;
  logic            fill_sel, fill_full, hsel, ovf, ovf_clr, rd_en;
  logic [CNT_W-1:0] fill_cnt, cnt0, cnt1;
  logic [1:0]      rdy, rel_req, rel_hit;
  logic [63:0]     rd_flat;

  rxpp_ingress #(.MSG_WORDS(MSG_WORDS), .BANK_WORDS(BANK_WORDS), .CNT_W(CNT_W)) u_ingress (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan),
    .in_last(in_last), .fill_sel(fill_sel), .fill_cnt(fill_cnt), .fill_full(fill_full),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .msg_done(msg_done), .msg_drop(msg_drop), .busy_next(busy_next), .writing(writing),
    .wptr(wptr)
  );

  rxpp_bank_ctrl #(.MAX_MSGS(MAX_MSGS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_done(msg_done), .msg_drop(msg_drop),
    .busy_next(busy_next), .rel_req(rel_req), .ovf_clr(ovf_clr), .rdy(rdy), .hsel(hsel),
    .fill_sel(fill_sel), .fill_cnt(fill_cnt), .cnt0(cnt0), .cnt1(cnt1),
    .fill_full(fill_full), .ovf(ovf), .rel_hit(rel_hit), .irq(irq)
  );

  rxpp_bank_mem #(.BANK_WORDS(BANK_WORDS)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_flat(rd_flat)
  );

  rxpp_host_regs #(.BANK_WORDS(BANK_WORDS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hb_en(hb_en), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .rdy(rdy), .ovf(ovf), .hsel(hsel), .cnt0(cnt0), .cnt1(cnt1),
    .rd_flat(rd_flat), .rel_req(rel_req), .ovf_clr(ovf_clr), .rd_en(rd_en),
    .rd_addr(rd_addr), .hb_rdata(hb_rdata)
  );

endmodule

// File: rtl/rxpp_pingpong_chk.sv
module rxpp_pingpong_chk #(
  parameter int MSG_WORDS = 4,
  parameter int MAX_MSGS  = 256,
  parameter int CNT_W     = 9,
  parameter int WP_W      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_last,
  input logic [WP_W-1:0] wptr,
  input logic            irq,
  input logic [1:0]      rdy,
  input logic            ovf,
  input logic            ovf_clr,
  input logic            msg_drop,
  input logic [1:0]      rel_hit,
  input logic            writing,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);

  // R3: input framing, last flag only on the final word
  a_r3_last_on_final_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |-> (wptr == WP_W'(MSG_WORDS - 1)));

  a_r5_one_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdy));

  a_r2_irq_marks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdy != 2'b00));

  a_r11_new_ready_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdy & ~$past(rdy)) != 2'b00) |-> irq);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    msg_drop |=> ovf);

  a_r8_release0_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit[0] |=> (!rdy[0] && cnt0 == '0));

  a_r8_release1_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit[1] |=> (!rdy[1] && cnt1 == '0));

  a_r10_irq_not_mid_message: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !writing);

  a_r4_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= CNT_W'(MAX_MSGS)) && (cnt1 <= CNT_W'(MAX_MSGS)));

endmodule

bind rxpp_pingpong rxpp_pingpong_chk #(
  .MSG_WORDS(MSG_WORDS), .MAX_MSGS(MAX_MSGS), .CNT_W(CNT_W), .WP_W(WP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .wptr(wptr),
  .irq(irq), .rdy(rdy), .ovf(ovf), .ovf_clr(ovf_clr), .msg_drop(msg_drop),
  .rel_hit(rel_hit), .writing(writing), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/rxpp_pingpong_bench.sv
module rxpp_pingpong_bench;

  localparam int MSGW  = 4;
  localparam int BANKW = 32;
  localparam int MAXM  = BANKW / MSGW;
  localparam int HA_W  = $clog2(BANKW) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_chan = '0;
  logic hb_en = 1'b0, hb_we = 1'b0;
  logic [HA_W-1:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic irq;

  always #2 clk = ~clk;

  rxpp_pingpong #(.MSG_WORDS(MSGW), .BANK_WORDS(BANKW)) u_rxpp_pingpong (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan),
    .in_last(in_last), .hb_en(hb_en), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int irq_seen = 0, exp_irq = 0;
  int m_cnt [2];
  bit m_rdy [2];
  bit m_ovf, m_hsel, m_fill;
  logic [31:0] m_mem [2][BANKW];
  bit done = 0;

  always @(posedge clk) if (rst_n && irq) irq_seen++;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return 32'(m_rdy[0]) + 32'(m_rdy[1]) * 2 + 32'(m_ovf) * 4 + 32'(m_hsel) * 8
         + 32'(m_cnt[0]) * 256 + 32'(m_cnt[1]) * 262144;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] d, input logic [2:0] ch);
    return (d & 32'h1fff_ffff) | (32'(ch) << 29);
  endfunction

  function automatic bit held();
    return m_rdy[0] || m_rdy[1];
  endfunction

  function automatic void hand_over();
    m_rdy[m_fill] = 1'b1;
    m_hsel = m_fill;
    m_fill = ~m_fill;
    exp_irq++;
  endfunction

  function automatic void model_release(input logic [1:0] bits);
    for (int b = 0; b < 2; b++)
      if (bits[b] && m_rdy[b]) begin
        m_rdy[b] = 1'b0;
        m_cnt[b] = 0;
      end
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    hb_en = 1; hb_we = 1; hb_addr = HA_W'(a); hb_wdata = d;
    @(negedge clk);
    hb_en = 0; hb_we = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    hb_en = 1; hb_we = 0; hb_addr = HA_W'(a);
    @(negedge clk);
    hb_en = 0;
    d = hb_rdata;
  endtask

  // rel_at < 0: no release during the message
  task automatic send_msg(input logic [2:0] ch, input bit gaps, input int rel_at,
                          input logic [1:0] rel_bits);
    bit drop;
    int slot;
    logic [31:0] d;
    drop = (m_cnt[m_fill] == MAXM);
    slot = m_cnt[m_fill];
    if (drop) m_ovf = 1'b1;
    for (int w = 0; w < MSGW; w++) begin
      if (gaps && ($urandom % 2 == 1)) begin
        @(negedge clk);
        in_valid = 0; in_last = 0; hb_en = 0;
      end
      @(negedge clk);
      d = $urandom;
      in_valid = 1; in_data = d; in_chan = ch; in_last = (w == MSGW - 1);
      if (w == rel_at) begin
        hb_en = 1; hb_we = 1; hb_addr = HA_W'(1); hb_wdata = {30'b0, rel_bits};
        model_release(rel_bits);
      end else begin
        hb_en = 0; hb_we = 0;
      end
      if (!drop) m_mem[m_fill][slot * MSGW + w] = (w == 0) ? exp_first(d, ch) : d;
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; hb_en = 0; hb_we = 0;
    if (!drop) begin
      m_cnt[m_fill]++;
      if (!held()) hand_over();
    end
  endtask

  task automatic release_bank(input logic [1:0] bits);
    bus_write(1, {30'b0, bits});
    model_release(bits);
    if (!held() && m_cnt[m_fill] > 0) hand_over();
  endtask

  task automatic check_status(input string req);
    logic [31:0] s;
    idle(2);
    bus_read(0, s);
    chk(req, "status", s, exp_status());
    chk(req, "irq count", 32'(irq_seen), 32'(exp_irq));
  endtask

  task automatic check_bank(input string req);
    logic [31:0] d;
    int n;
    n = m_cnt[m_hsel] * MSGW;
    for (int i = 0; i < n; i++) begin
      bus_read(BANKW + i, d);
      chk(req, $sformatf("bank%0d word %0d", m_hsel, i), d, m_mem[m_hsel][i]);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_cnt[0] = 0; m_cnt[1] = 0; m_rdy[0] = 0; m_rdy[1] = 0;
    m_ovf = 0; m_hsel = 0; m_fill = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check_status("R1");
    // R7: releases with nothing held change nothing; command reads 0
    release_bank(2'b11);
    check_status("R7");
    bus_read(1, r);
    chk("R7", "command readback", r, 32'h0);
    // R2: first message hands bank 0 over
    send_msg(3'd5, 0, -1, 2'b00);
    check_status("R2");
    // R3: stored contents with channel tag
    check_bank("R3");
    // R4: next message fills bank 1 without interrupt
    send_msg(3'd2, 1, -1, 2'b00);
    check_status("R4");
    // R7: release of a bank not held is ignored
    release_bank(2'b10);
    check_status("R7");
    // R10: release mid-message defers handover to message end
    send_msg(3'd7, 0, 2, 2'b01);
    check_status("R10");
    check_bank("R10");
    // R6: release with empty other bank, no interrupt yet
    release_bank(2'b11);
    check_status("R6");
    send_msg(3'd1, 1, -1, 2'b00);
    check_status("R6");
    // R9: fill bank 1 beyond capacity
    for (int i = 0; i < MAXM + 1; i++) send_msg(3'(i), 0, -1, 2'b00);
    check_status("R9");
    bus_write(0, 32'h4);
    m_ovf = 0;
    check_status("R9");
    // R5 / R8: release bank 0, full bank 1 handed over at once
    release_bank(2'b01);
    check_status("R5");
    check_bank("R8");

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 10;
      if (op < 6) begin
        send_msg(3'($urandom), 1'($urandom), -1, 2'b00);
      end else if (op < 9) begin
        if (held()) begin
          logic [1:0] bits;
          check_bank("R3");
          bits = m_hsel ? 2'b10 : 2'b01;
          if ($urandom % 2 == 1) bits = 2'b11;
          release_bank(bits);
        end
      end else begin
        bus_write(0, 32'h4);
        m_ovf = 0;
      end
      if (it % 8 == 0) check_status("R11");
    end
    check_status("R11");
    done = 1;
    report();
  end

endmodule